// File: doc/BRIEF.md
# Three-Table Logic Cell with Carry and Table RAM

This block is one configurable logic cell. Two 4-input lookup tables, F and G, each give any function of their own four inputs. A third, 3-input table, H, combines the F result, the G result and one extra input. Together they give any 5-input function, or selected functions of up to nine inputs such as a 9-input AND or a 9-input parity. The F and G results also leave the cell as two separate outputs. A dedicated two-bit carry path supports arithmetic. In arithmetic mode it replaces the F and G results with sum bits and passes a carry to the next cell.

The F and G tables are registers that take their configured contents from the table ports while reset is asserted. In the two RAM modes they become writable memory with a synchronous write and a combinational read. In single-port RAM mode, F and G form one 16x2 memory. In dual-port RAM mode, both tables hold the same 16x1 data: F reads at the write address and G reads at its own address.

Two flip-flops each choose a data source. They share one clock, one enable and one clear. Their outputs leave the cell without being fed back inside it.

Top module: `tri_lut_cell`

## Requirements
- R1: In logic mode (`mode`=00), `f_out` equals `f_tab[f_in]` and `g_out` equals `g_tab[g_in]`, as loaded at the last reset.
- R2: `h_out` always equals `h_tab[{h_in, g_out, f_out}]`: bit 2 of the index is `h_in`, bit 1 is the G result and bit 0 is the F result.
- R3: With F, G and H configured together, the cell gives one function of nine inputs: `f_in`, `g_in` and `h_in`.
- R4: In arithmetic mode (`mode`=01), `{carry_out, g_out, f_out}` equals `{g_in[0],f_in[0]} + {g_in[1],f_in[1]} + carry_in`. In every other mode `carry_out` is 0.
- R5: In single-port RAM mode (`mode`=10), a clock edge with `wr_en`=1 writes `wr_data[0]` into F and `wr_data[1]` into G at address `f_in`. Both tables are read at `f_in`.
- R6: In dual-port RAM mode (`mode`=11), a write stores `wr_data[0]` at address `f_in` in both tables. `f_out` reads at `f_in` and `g_out` reads at the independent address `g_in`.
- R7: A read at the address being written returns the old contents until the write edge.
- R8: In logic and arithmetic modes, `wr_en` has no effect on table contents.
- R9: When `reg_ce`=1, each flip-flop loads the source chosen by its 2-bit select: 00 picks its own table (F for bit 0, G for bit 1), 01 picks H, and 1x picks its `reg_ext` bit.
- R10: When `reg_ce`=0, both flip-flops hold. `reg_clr`=1 clears both flip-flops at the edge, whatever `reg_ce` is.
- R11: While `rst_n`=0, a clock edge clears both flip-flops and reloads F and G from `f_tab` and `g_tab`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low reset; reloads tables |
| mode | input | 2 | 00 logic, 01 arithmetic, 10 single-port RAM, 11 dual-port RAM |
| f_tab | input | 16 | F table contents loaded at reset |
| g_tab | input | 16 | G table contents loaded at reset |
| h_tab | input | 8 | H table contents |
| f_in | input | 4 | F address / operand bits / RAM address |
| g_in | input | 4 | G address / operand bits / dual-port read address |
| h_in | input | 1 | Extra H input |
| carry_in | input | 1 | Carry from the previous cell |
| wr_en | input | 1 | Table write enable in RAM modes |
| wr_data | input | 2 | Table write data |
| reg_ce | input | 1 | Shared flip-flop enable |
| reg_clr | input | 1 | Shared flip-flop synchronous clear |
| reg0_src | input | 2 | Data select for flip-flop 0 |
| reg1_src | input | 2 | Data select for flip-flop 1 |
| reg_ext | input | 2 | External flip-flop data |
| f_out | output | 1 | F result or sum bit 0 |
| g_out | output | 1 | G result or sum bit 1 |
| h_out | output | 1 | H result |
| carry_out | output | 1 | Carry to the next cell |
| q_out | output | 2 | Flip-flop outputs |

## Verification
The assertions take `mode`, the table ports and the select inputs as settled values at each rising edge. They also take the flip-flop enable and clear as plain synchronous controls. The checks on the sum and the H mapping compare combinational outputs at the edge, so they assume no input changes close to the edge. The stimulus changes every input only at the falling clock edge. It leaves `wr_en` high across mode changes only where R8 is the point being exercised.

// File: rtl/tlc_pkg.sv
// Shared types for the three-table logic cell.
package tlc_pkg;
    // Operating mode of the cell.
    typedef enum logic [1:0] {
        MODE_LOGIC   = 2'b00,
        MODE_ARITH   = 2'b01,
        MODE_RAM     = 2'b10,
        MODE_DUALRAM = 2'b11
    } cell_mode_e;

    // Flip-flop data select codes (upper bit set selects external data).
    localparam logic [1:0] SRC_OWN = 2'b00;
    localparam logic [1:0] SRC_H   = 2'b01;
endpackage

// File: rtl/tlc_table.sv
// Lookup table held in registers; doubles as a 1-bit-wide RAM.
// Assumes: init is stable while reset is asserted; read is combinational,
// so a same-cycle read of the written address returns the old bit.
module tlc_table #(
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [(1<<AW)-1:0]  init,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic                wdata,
    input  logic [AW-1:0]       raddr,
    output logic                rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] bits;

    // Reload configured contents on reset, else apply a synchronous write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= init;
        end else if (we) begin
            bits[waddr] <= wdata;
        end
    end

    // Asynchronous read port.
    assign rdata = bits[raddr];
endmodule

// File: rtl/tlc_carry.sv
// Dedicated ripple carry path producing NB sum bits and a carry out.
// Assumes: operands arrive LSB first; carry enters at bit 0.
module tlc_carry #(
    parameter int NB = 2
) (
    input  logic [NB-1:0] a,
    input  logic [NB-1:0] b,
    input  logic          cin,
    output logic [NB-1:0] sum,
    output logic          cout
);
    logic [NB:0] chain;

    assign chain[0] = cin;

    // One full-adder stage per bit, carry rippling upward.
    for (genvar i = 0; i < NB; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
    end

    assign cout = chain[NB];
endmodule

// File: rtl/tlc_regpair.sv
// Two flip-flops with individual data selects and shared enable/clear.
// Assumes: clear dominates enable; outputs are not looped back in here.
module tlc_regpair
    import tlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       clr,
    input  logic [1:0] own,
    input  logic       hval,
    input  logic [1:0] ext,
    input  logic [1:0] src0,
    input  logic [1:0] src1,
    output logic [1:0] q
);
    logic [1:0] sel [2];

    assign sel[0] = src0;
    assign sel[1] = src1;

    for (genvar i = 0; i < 2; i++) begin : g_ff
        logic d;

        // Pick this flip-flop's data source.
        always_comb begin
            if (sel[i][1])            d = ext[i];
            else if (sel[i] == SRC_H) d = hval;
            else                      d = own[i];
        end

        // Shared reset, clear and enable.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                q[i] <= 1'b0;
            end else if (ce) begin
                q[i] <= d;
            end
        end
    end
endmodule

// File: rtl/tri_lut_cell.sv
// Logic cell: F and G 4-input tables, H 3-input combiner, 2-bit carry path,
// table RAM modes and two flip-flops with shared controls.
// Assumes: mode and table ports are configuration, changed only between uses.
module tri_lut_cell
    import tlc_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode,
    input  logic [(1<<LUT_K)-1:0] f_tab,
    input  logic [(1<<LUT_K)-1:0] g_tab,
    input  logic [7:0]            h_tab,
    input  logic [LUT_K-1:0]      f_in,
    input  logic [LUT_K-1:0]      g_in,
    input  logic                  h_in,
    input  logic                  carry_in,
    input  logic                  wr_en,
    input  logic [1:0]            wr_data,
    input  logic                  reg_ce,
    input  logic                  reg_clr,
    input  logic [1:0]            reg0_src,
    input  logic [1:0]            reg1_src,
    input  logic [1:0]            reg_ext,
    output logic                  f_out,
    output logic                  g_out,
    output logic                  h_out,
    output logic                  carry_out,
    output logic [1:0]            q_out
);
    localparam int SUM_W = 2;

    cell_mode_e           m;
    logic                 ram_mode;
    logic                 tab_we;
    logic                 g_wdata;
    logic [LUT_K-1:0]     g_raddr;
    logic                 f_rd;
    logic                 g_rd;
    logic [SUM_W-1:0]     sum;
    logic                 cout_raw;
    logic                 f_res;
    logic                 g_res;

    assign m        = cell_mode_e'(mode);
    assign ram_mode = (m == MODE_RAM) || (m == MODE_DUALRAM);
    assign tab_we   = wr_en && ram_mode;

    // Route write data and G read address per RAM flavour.
    always_comb begin
        g_wdata = (m == MODE_DUALRAM) ? wr_data[0] : wr_data[1];
        g_raddr = (m == MODE_RAM) ? f_in : g_in;
    end

    tlc_table #(.AW(LUT_K)) u_ftab (
        .clk(clk), .rst_n(rst_n), .init(f_tab), .we(tab_we),
        .waddr(f_in), .wdata(wr_data[0]), .raddr(f_in), .rdata(f_rd)
    );

    tlc_table #(.AW(LUT_K)) u_gtab (
        .clk(clk), .rst_n(rst_n), .init(g_tab), .we(tab_we),
        .waddr(f_in), .wdata(g_wdata), .raddr(g_raddr), .rdata(g_rd)
    );

    tlc_carry #(.NB(SUM_W)) u_carry (
        .a({g_in[0], f_in[0]}), .b({g_in[1], f_in[1]}), .cin(carry_in),
        .sum(sum), .cout(cout_raw)
    );

    // Select table results or sum bits, then combine in H.
    always_comb begin
        if (m == MODE_ARITH) begin
            f_res     = sum[0];
            g_res     = sum[1];
            carry_out = cout_raw;
        end else begin
            f_res     = f_rd;
            g_res     = g_rd;
            carry_out = 1'b0;
        end
        h_out = h_tab[{h_in, g_res, f_res}];
    end

    assign f_out = f_res;
    assign g_out = g_res;

    tlc_regpair u_regs (
        .clk(clk), .rst_n(rst_n), .ce(reg_ce), .clr(reg_clr),
        .own({g_res, f_res}), .hval(h_out), .ext(reg_ext),
        .src0(reg0_src), .src1(reg1_src), .q(q_out)
    );
endmodule

// File: rtl/tri_lut_cell_chk.sv
// Property checker for tri_lut_cell, attached through bind.
// Assumes: inputs settle between clock edges.
module tri_lut_cell_chk #(
    parameter int LUT_K = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [7:0]       h_tab,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_in,
    input  logic             carry_in,
    input  logic             reg_ce,
    input  logic             reg_clr,
    input  logic [1:0]       reg0_src,
    input  logic [1:0]       reg1_src,
    input  logic [1:0]       reg_ext,
    input  logic             f_out,
    input  logic             g_out,
    input  logic             h_out,
    input  logic             carry_out,
    input  logic [1:0]       q_out
);
    logic [2:0] add_ref;
    assign add_ref = {1'b0, g_in[0], f_in[0]} + {1'b0, g_in[1], f_in[1]} + {2'b00, carry_in};

    AST_H_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        h_out == h_tab[{h_in, g_out, f_out}]);  // R2
    AST_ARITH_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> ({carry_out, g_out, f_out} == add_ref));  // R4
    AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b01) |-> !carry_out);  // R4
    AST_OWN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ce && !reg_clr && reg0_src == 2'b00) |=> q_out[0] == $past(f_out));  // R9
    AST_EXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ce && !reg_clr && reg1_src[1]) |=> q_out[1] == $past(reg_ext[1]));  // R9
    AST_H_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ce && !reg_clr && reg1_src == 2'b01) |=> q_out[1] == $past(h_out));  // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_ce && !reg_clr) |=> $stable(q_out));  // R10
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr |=> (q_out == 2'b00));  // R10
endmodule

bind tri_lut_cell tri_lut_cell_chk #(.LUT_K(LUT_K)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .h_tab(h_tab),
    .f_in(f_in), .g_in(g_in), .h_in(h_in), .carry_in(carry_in),
    .reg_ce(reg_ce), .reg_clr(reg_clr), .reg0_src(reg0_src),
    .reg1_src(reg1_src), .reg_ext(reg_ext), .f_out(f_out),
    .g_out(g_out), .h_out(h_out), .carry_out(carry_out), .q_out(q_out)
);

// File: tb/tri_lut_cell_bench.sv
// Self-checking bench: vector table for combinational behaviour, then
// directed tests for RAM, flip-flops and reset.
module tri_lut_cell_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic [15:0] f_tab, g_tab;
    logic [7:0]  h_tab;
    logic [3:0]  f_in, g_in;
    logic        h_in, carry_in, wr_en;
    logic [1:0]  wr_data;
    logic        reg_ce, reg_clr;
    logic [1:0]  reg0_src, reg1_src, reg_ext;
    logic        f_out, g_out, h_out, carry_out;
    logic [1:0]  q_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tri_lut_cell u_tri_lut_cell (
        .clk(clk), .rst_n(rst_n), .mode(mode), .f_tab(f_tab), .g_tab(g_tab),
        .h_tab(h_tab), .f_in(f_in), .g_in(g_in), .h_in(h_in),
        .carry_in(carry_in), .wr_en(wr_en), .wr_data(wr_data),
        .reg_ce(reg_ce), .reg_clr(reg_clr), .reg0_src(reg0_src),
        .reg1_src(reg1_src), .reg_ext(reg_ext), .f_out(f_out),
        .g_out(g_out), .h_out(h_out), .carry_out(carry_out), .q_out(q_out)
    );

    // Vector: {mode, f_in, g_in, h_in, carry_in, exp {f,g,h,carry}}.
    // F = 4-input AND, G = 4-input parity, H = 3-input AND.
    localparam logic [15:0] VEC [0:8] = '{
        {2'd0, 4'hF, 4'h0, 1'b1, 1'b0, 4'b1000},
        {2'd0, 4'hF, 4'h7, 1'b1, 1'b0, 4'b1110},
        {2'd0, 4'hE, 4'h7, 1'b1, 1'b0, 4'b0100},
        {2'd0, 4'hF, 4'h3, 1'b1, 1'b0, 4'b1000},
        {2'd0, 4'hF, 4'h1, 1'b0, 1'b0, 4'b1100},
        {2'd1, 4'h3, 4'h0, 1'b1, 1'b0, 4'b0100},
        {2'd1, 4'h3, 4'h3, 1'b1, 1'b1, 4'b1111},
        {2'd1, 4'h2, 4'h1, 1'b1, 1'b1, 4'b0001},
        {2'd1, 4'h2, 4'h1, 1'b0, 1'b0, 4'b1100}
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(100000 * 10);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'd0;
        f_tab = 16'h8000; g_tab = 16'h6996; h_tab = 8'h80;
        f_in = 4'h0; g_in = 4'h0; h_in = 1'b0; carry_in = 1'b0;
        wr_en = 1'b0; wr_data = 2'b00;
        reg_ce = 1'b1; reg_clr = 1'b0; reg0_src = 2'b00; reg1_src = 2'b00; reg_ext = 2'b11;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R11 reset clears flops", {2'b00, q_out}, 4'b0000);

        // Vector walk: R1 R2 R3 for logic entries, R4 for arithmetic ones.
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            {mode, f_in, g_in, h_in, carry_in} = VEC[i][15:4];
            #1;
            chk((i < 5) ? "R1 R2 R3 R4 logic vector" : "R4 R2 arith vector",
                {f_out, g_out, h_out, carry_out}, VEC[i][3:0]);
        end

        // R8: write in logic mode is ignored (F[15] stays 1).
        @(negedge clk); mode = 2'd0; f_in = 4'hF; wr_en = 1'b1; wr_data = 2'b00;
        tick;
        @(negedge clk); wr_en = 1'b0;
        #1 chk("R8 logic-mode write ignored", {3'b000, f_out}, 4'b0001);

        // R8: write in arithmetic mode is ignored, seen after returning to logic.
        @(negedge clk); mode = 2'd1; f_in = 4'hF; wr_en = 1'b1;
        tick;
        @(negedge clk); wr_en = 1'b0; mode = 2'd0;
        #1 chk("R8 arith-mode write ignored", {3'b000, f_out}, 4'b0001);

        // R5 / R7: single-port RAM write at address 5.
        @(negedge clk); mode = 2'd2; f_in = 4'h5; g_in = 4'h0; wr_data = 2'b11; wr_en = 1'b1;
        #1 chk("R7 old data before write edge", {2'b00, f_out, g_out}, 4'b0000);
        tick;
        chk("R5 single-port write both tables", {2'b00, f_out, g_out}, 4'b0011);
        @(negedge clk); wr_en = 1'b0;

        // R6 / R7: dual-port, write 0 at address 1, G reading address 1.
        @(negedge clk); mode = 2'd3; f_in = 4'h1; g_in = 4'h1; wr_data = 2'b00; wr_en = 1'b1;
        #1 chk("R7 dual-port old data", {3'b000, g_out}, 4'b0001);
        tick;
        chk("R6 dual-port write seen on G port", {3'b000, g_out}, 4'b0000);
        @(negedge clk); wr_en = 1'b0; f_in = 4'h4; g_in = 4'h1;
        #1 chk("R6 independent read addresses", {2'b00, f_out, g_out}, 4'b0000);
        @(negedge clk); f_in = 4'h4; g_in = 4'h7; wr_data = 2'b01; wr_en = 1'b1;
        tick;
        chk("R6 write address 4, G reads 7", {2'b00, f_out, g_out}, 4'b0011);
        @(negedge clk); wr_en = 1'b0;

        // R11: reset reloads the F table (F[5] back to 0).
        @(negedge clk); mode = 2'd0; f_in = 4'h5; rst_n = 1'b0;
        tick; tick;
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R11 table reload", {3'b000, f_out}, 4'b0000);

        // R9 / R10: flip-flop sources and shared controls.
        @(negedge clk); f_in = 4'hF; g_in = 4'h7; h_in = 1'b1;
        reg0_src = 2'b00; reg1_src = 2'b00; reg_ce = 1'b1; reg_clr = 1'b0;
        tick;
        chk("R9 own-table sources", {2'b00, q_out}, 4'b0011);
        @(negedge clk); h_in = 1'b0; reg0_src = 2'b01; reg1_src = 2'b10; reg_ext = 2'b00;
        tick;
        chk("R9 H and external sources", {2'b00, q_out}, 4'b0000);
        @(negedge clk); reg_ce = 1'b0; reg0_src = 2'b00; reg1_src = 2'b00;
        tick;
        chk("R10 enable low holds", {2'b00, q_out}, 4'b0000);
        @(negedge clk); reg_ce = 1'b1; reg_clr = 1'b1;
        tick;
        chk("R10 clear dominates", {2'b00, q_out}, 4'b0000);
        @(negedge clk); reg_clr = 1'b0; reg0_src = 2'b10; reg1_src = 2'b11; reg_ext = 2'b01;
        tick;
        chk("R9 external per-bit", {2'b00, q_out}, 4'b0001);
        @(negedge clk); reg_ce = 1'b0; reg_ext = 2'b10;
        tick;
        chk("R10 hold ignores new data", {2'b00, q_out}, 4'b0001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule